// File: doc/BRIEF.md
# Configurable-Length SPI Slave with Overrun Flag

This block is a serial slave that sits on a four-wire bus and runs on the system clock. While the active-low select is held low, it shifts in a word from MOSI, most significant bit first. At the same time it drives a word from its transmit register onto MISO. The word length can be set anywhere from 8 to 16 bits, so unusual sizes such as 10-bit words pass through without any padding. Clock polarity and phase are set by two configuration bits. The phase bit has inverted sense: when it is set, the slave samples on the leading edge.

The select, clock and data pins are first passed through a chain of synchronizer flops, and the edges of the serial clock are then detected in the system clock domain. When a word is complete, it is placed right-aligned in the receive register and the ready flag goes high. If a word completes while the previous one is still unread, the new word still replaces it and a sticky overrun flag is raised. Reading the data clears ready. Only a status read clears overrun. The transmit register is copied into the output shifter while select is idle and again at every word boundary. This lets a host queue the next word while the current one is still being shifted.

Top module: `spi_word_slave`

## Requirements
- R1: After reset, rx_data is 0, rx_ready is 0, rx_overrun is 0 and miso is 0.
- R2: A cfg_len_sel value k from 0 to 8 selects 8+k bits per word, and any value above 8 selects 16 bits. The received word sits in the low bits of rx_data, with every bit above the word length at 0.
- R3: cfg_cpol gives the idle level of sck, so the leading edge is rising when it is 0 and falling when it is 1. When cfg_ncpha is 1, MOSI is sampled on the leading edge; when it is 0, it is sampled on the trailing edge.
- R4: The first bit sampled becomes the word's MSB. On the last bit, the word loads into rx_data and rx_ready goes to 1.
- R5: MISO carries the transmit word MSB first, and each bit is stable before the sample edge that the master uses for it. While select is high, MISO shows transmit bit (length-1). The output shifter takes a copy of the transmit register only while select is idle or at a word boundary, so a write in the middle of a word affects only the next word.
- R6: Edges on sck while ss_n is high are ignored.
- R7: If ss_n rises partway through a word, the partial bits are dropped and the next selection starts a fresh word.
- R8: A pulse on rd_data_en clears rx_ready. If a word completes in the same cycle, rx_ready stays 1 and no overrun is raised.
- R9: If a word completes while rx_ready is 1 and no data read happens in that cycle, rx_overrun goes to 1 and rx_data still takes the new word.
- R10: rx_overrun stays set until a pulse on rd_stat_en; data reads leave it unchanged. A new overrun in the same cycle as a status read keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_len_sel | input | 4 | Word length select (8 + value, clamped to 16) |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_ncpha | input | 1 | 1: sample on the leading edge, 0: sample on the trailing edge |
| ss_n | input | 1 | Slave select, active low |
| sck | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| tx_wr_en | input | 1 | Write strobe for the transmit register |
| tx_wdata | input | 16 | Transmit word, right-aligned |
| rd_data_en | input | 1 | Receive data read strobe |
| rd_stat_en | input | 1 | Status read strobe |
| rx_data | output | 16 | Last received word, right-aligned |
| rx_ready | output | 1 | Unread word present |
| rx_overrun | output | 1 | A word was overwritten before it was read |

## Verification
The assertions check several things on every cycle:
- the bit counter never reaches the word length;
- an idle select always resets the counter;
- a completed word always sets ready and clears the bits above the length;
- an unread completion always raises overrun;
- the receive register changes only when a word completes;
- each read strobe clears its own flag.

Three behaviours can only be shown by the bench's scenarios, because they depend on whole serial transfers: the bit order under all four clock modes and every word length, the data the master recovers from MISO, and the reload of the transmit word between back-to-back words. The same holds for the exact cycle in which a read coincides with a completion.

// File: rtl/spi_word_slave_pkg.sv
package spi_word_slave_pkg;
  localparam int WMAX     = 16;
  localparam int WMIN     = 8;
  localparam int LENW     = $clog2(WMAX + 1);
  localparam int SELW     = 4;

  // bits per word from the select field, clamped to the maximum
  function automatic logic [LENW-1:0] word_len(input logic [SELW-1:0] sel);
    logic [LENW-1:0] r;
    if (int'(sel) > WMAX - WMIN) r = LENW'(WMAX);
    else                         r = LENW'(WMIN) + LENW'(sel);
    return r;
  endfunction

  // mask with the low n bits set
  function automatic logic [WMAX-1:0] len_mask(input logic [LENW-1:0] n);
    logic [WMAX:0] t;
    t = ((WMAX+1)'(1) << n) - (WMAX+1)'(1);
    return t[WMAX-1:0];
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ss_n,
  input  logic sck,
  input  logic mosi,
  input  logic cpol,
  input  logic ncpha,
  output logic ss_act,
  output logic samp,
  output logic mosi_s
);
  // each stage holds {ss_n, sck, mosi}
  logic [STAGES-1:0][2:0] chain;
  logic sck_q;
  logic sck_s, rise, fall, lead, trail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= 3'b100;
      sck_q <= 1'b0;
    end else begin
      chain[0] <= {ss_n, sck, mosi};
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      sck_q <= chain[STAGES-1][1];
    end
  end

  assign sck_s  = chain[STAGES-1][1];
  assign mosi_s = chain[STAGES-1][0];
  assign ss_act = ~chain[STAGES-1][2];
  assign rise   = sck_s & ~sck_q;
  assign fall   = ~sck_s & sck_q;
  assign lead   = cpol ? fall : rise;
  assign trail  = cpol ? rise : fall;
  assign samp   = ss_act & (ncpha ? lead : trail);
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_word_slave_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ss_act,
  input  logic            samp,
  input  logic            mosi_s,
  input  logic [LENW-1:0] len,
  input  logic [WMAX-1:0] tx_reg,
  output logic            word_done,
  output logic [WMAX-1:0] word,
  output logic            miso_bit
);
  logic [LENW-1:0] cnt;
  logic [WMAX-2:0] sh;
  logic [WMAX-1:0] tx_cur;
  logic            last_bit;
  logic [3:0]      out_idx, idle_idx;

  assign last_bit  = (cnt == len - LENW'(1));
  assign word_done = samp & last_bit;
  assign word      = {sh, mosi_s} & len_mask(len);
  assign out_idx   = 4'(len - LENW'(1) - cnt);
  assign idle_idx  = 4'(len - LENW'(1));
  assign miso_bit  = ss_act ? tx_cur[out_idx] : tx_reg[idle_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      sh     <= '0;
      tx_cur <= '0;
    end else if (!ss_act) begin
      cnt    <= '0;
      sh     <= '0;
      tx_cur <= tx_reg;
    end else if (samp) begin
      if (last_bit) begin
        cnt    <= '0;
        sh     <= '0;
        tx_cur <= tx_reg;
      end else begin
        cnt <= cnt + LENW'(1);
        sh  <= {sh[WMAX-3:0], mosi_s};
      end
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < len);
  // R7
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_act |=> cnt == '0);
endmodule

// File: rtl/spi_rx_status.sv
module spi_rx_status
  import spi_word_slave_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            word_done,
  input  logic [WMAX-1:0] word,
  input  logic [LENW-1:0] len,
  input  logic            rd_data_en,
  input  logic            rd_stat_en,
  output logic [WMAX-1:0] rx_data,
  output logic            ready,
  output logic            overrun
);
  logic ovr_event;
  assign ovr_event = word_done & ready & ~rd_data_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      ready   <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (word_done) rx_data <= word;
      if (word_done)       ready <= 1'b1;
      else if (rd_data_en) ready <= 1'b0;
      if (ovr_event)       overrun <= 1'b1;
      else if (rd_stat_en) overrun <= 1'b0;
    end
  end

  // R4
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> ready);
  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> (rx_data & ~len_mask($past(len))) == '0);
  // R9
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && ready && !rd_data_en) |=> overrun);
  // R10
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat_en && !(word_done && ready && !rd_data_en)) |=> !overrun);
  // R8
  data_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_en && !word_done) |=> !ready);
  // R4
  hold_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_done |=> $stable(rx_data));
endmodule

// File: rtl/spi_word_slave.sv
module spi_word_slave
  import spi_word_slave_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SELW-1:0] cfg_len_sel,
  input  logic            cfg_cpol,
  input  logic            cfg_ncpha,
  input  logic            ss_n,
  input  logic            sck,
  input  logic            mosi,
  output logic            miso,
  input  logic            tx_wr_en,
  input  logic [WMAX-1:0] tx_wdata,
  input  logic            rd_data_en,
  input  logic            rd_stat_en,
  output logic [WMAX-1:0] rx_data,
  output logic            rx_ready,
  output logic            rx_overrun
);
  logic [LENW-1:0] len;
  logic [WMAX-1:0] tx_reg, word;
  logic            ss_act, samp, mosi_s, word_done;

  assign len = word_len(cfg_len_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tx_reg <= '0;
    else if (tx_wr_en) tx_reg <= tx_wdata;
  end

  spi_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .sck(sck), .mosi(mosi),
    .cpol(cfg_cpol), .ncpha(cfg_ncpha),
    .ss_act(ss_act), .samp(samp), .mosi_s(mosi_s));

  spi_shift_core core_i (
    .clk(clk), .rst_n(rst_n), .ss_act(ss_act), .samp(samp), .mosi_s(mosi_s),
    .len(len), .tx_reg(tx_reg),
    .word_done(word_done), .word(word), .miso_bit(miso));

  spi_rx_status stat_i (
    .clk(clk), .rst_n(rst_n), .word_done(word_done), .word(word), .len(len),
    .rd_data_en(rd_data_en), .rd_stat_en(rd_stat_en),
    .rx_data(rx_data), .ready(rx_ready), .overrun(rx_overrun));
endmodule

// File: tb/spi_word_slave_tb_top.sv
module spi_word_slave_tb_top;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] cfg_len_sel = '0;
  logic cfg_cpol = 1'b0, cfg_ncpha = 1'b1;
  logic ss_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso;
  logic tx_wr_en = 1'b0;
  logic [15:0] tx_wdata = '0;
  logic rd_data_en = 1'b0, rd_stat_en = 1'b0;
  logic [15:0] rx_data;
  logic rx_ready, rx_overrun;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spi_word_slave dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_len_sel(cfg_len_sel), .cfg_cpol(cfg_cpol),
    .cfg_ncpha(cfg_ncpha), .ss_n(ss_n), .sck(sck), .mosi(mosi), .miso(miso),
    .tx_wr_en(tx_wr_en), .tx_wdata(tx_wdata), .rd_data_en(rd_data_en),
    .rd_stat_en(rd_stat_en), .rx_data(rx_data), .rx_ready(rx_ready),
    .rx_overrun(rx_overrun));

  task automatic wait_clk(input int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int bits_of(input int k);
    return (k > 8) ? 16 : 8 + k;
  endfunction

  function automatic logic [15:0] mask_of(input int n);
    return 16'((32'd1 << n) - 1);
  endfunction

  task automatic write_tx(input logic [15:0] v);
    tx_wdata = v; tx_wr_en = 1'b1;
    wait_clk(1);
    tx_wr_en = 1'b0;
  endtask

  task automatic read_data();
    rd_data_en = 1'b1; wait_clk(1); rd_data_en = 1'b0; wait_clk(1);
  endtask

  task automatic read_stat();
    rd_stat_en = 1'b1; wait_clk(1); rd_stat_en = 1'b0; wait_clk(1);
  endtask

  // master side: sends n bits of mo MSB first, captures MISO before each sample edge
  task automatic run_word(input logic [15:0] mo, input int n, input bit rd_at_end,
                          output logic [15:0] mi);
    mi = '0;
    for (int i = n - 1; i >= 0; i--) begin
      if (cfg_ncpha) begin
        mosi = mo[i];
        wait_clk(H);
        mi[i] = miso;
        sck = ~cfg_cpol;
      end else begin
        sck = ~cfg_cpol;
        mosi = mo[i];
        wait_clk(H);
        mi[i] = miso;
        sck = cfg_cpol;
      end
      if (rd_at_end && i == 0) begin
        wait_clk(2); rd_data_en = 1'b1; wait_clk(1); rd_data_en = 1'b0; wait_clk(H - 3);
      end else begin
        wait_clk(H);
      end
      sck = cfg_cpol;
    end
  endtask

  task automatic frame(input logic [15:0] mo, input int n, output logic [15:0] mi);
    ss_n = 1'b0; wait_clk(H);
    run_word(mo, n, 1'b0, mi);
    wait_clk(H); ss_n = 1'b1; wait_clk(6);
  endtask

  task automatic set_mode(input int m, input int k);
    cfg_cpol = m[1]; cfg_ncpha = m[0]; cfg_len_sel = 4'(k);
    sck = m[1];
    wait_clk(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] mi, mi2, mo, txv, prev;
    int n;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    // R1 reset state
    chk(rx_data == 16'h0, "R1 rx_data", rx_data, 16'h0);
    chk(rx_ready == 1'b0, "R1 ready", {15'h0, rx_ready}, 16'h0);
    chk(rx_overrun == 1'b0, "R1 overrun", {15'h0, rx_overrun}, 16'h0);
    chk(miso == 1'b0, "R1 miso", {15'h0, miso}, 16'h0);

    // R2 R3 R4 R5 sweep over modes, lengths (incl. clamp) and two patterns
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 10; k++) begin
        for (int p = 0; p < 2; p++) begin
          set_mode(m, k);
          n = bits_of(k);
          mo  = 16'((m * 7919 + k * 2311 + p * 40503) * 31 + 16'h5A3C) ^ (p ? 16'hFFFF : 16'h0);
          txv = 16'((k * 613 + m * 4099 + p * 1013) * 57 + 16'h1E2D);
          write_tx(txv);
          wait_clk(2);
          chk(miso == txv[n-1], "R5 idle miso", {15'h0, miso}, {15'h0, txv[n-1]});
          frame(mo, n, mi);
          chk(rx_data == (mo & mask_of(n)), "R2/R3/R4 rx word", rx_data, mo & mask_of(n));
          chk(rx_ready == 1'b1, "R4 ready set", {15'h0, rx_ready}, 16'h1);
          chk(mi == (txv & mask_of(n)), "R5 miso word", mi, txv & mask_of(n));
          read_data();
          chk(rx_ready == 1'b0, "R8 read clears ready", {15'h0, rx_ready}, 16'h0);
          chk(rx_overrun == 1'b0, "R9 no overrun", {15'h0, rx_overrun}, 16'h0);
        end
      end
    end

    // directed tests in mode cpol=0, ncpha=1, 10-bit words
    set_mode(1, 2);
    prev = rx_data;
    // R6: clock activity with select idle
    mosi = 1'b1;
    for (int i = 0; i < 24; i++) begin sck = ~sck; wait_clk(H); end
    sck = 1'b0; wait_clk(6);
    chk(rx_ready == 1'b0, "R6 ignored ready", {15'h0, rx_ready}, 16'h0);
    chk(rx_data == prev, "R6 ignored data", rx_data, prev);

    // R7: aborted partial word then a full word
    ss_n = 1'b0; wait_clk(H);
    run_word(16'h001F, 5, 1'b0, mi);
    wait_clk(H); ss_n = 1'b1; wait_clk(6);
    chk(rx_ready == 1'b0, "R7 partial no ready", {15'h0, rx_ready}, 16'h0);
    chk(rx_data == prev, "R7 partial no load", rx_data, prev);
    frame(16'h02C5, 10, mi);
    chk(rx_data == 16'h02C5, "R7 fresh word", rx_data, 16'h02C5);
    chk(rx_ready == 1'b1, "R7 ready", {15'h0, rx_ready}, 16'h1);

    // R9: second word unread -> overrun, data overwritten
    chk(rx_overrun == 1'b0, "R9 before", {15'h0, rx_overrun}, 16'h0);
    frame(16'h0133, 10, mi);
    chk(rx_overrun == 1'b1, "R9 overrun set", {15'h0, rx_overrun}, 16'h1);
    chk(rx_data == 16'h0133, "R9 overwrite", rx_data, 16'h0133);
    // R10: data read leaves overrun, status read clears it
    read_data();
    chk(rx_ready == 1'b0, "R8 cleared", {15'h0, rx_ready}, 16'h0);
    chk(rx_overrun == 1'b1, "R10 data read keeps", {15'h0, rx_overrun}, 16'h1);
    read_stat();
    chk(rx_overrun == 1'b0, "R10 stat read clears", {15'h0, rx_overrun}, 16'h0);

    // R8: read in the completion cycle keeps ready, no overrun
    frame(16'h0255, 10, mi);
    ss_n = 1'b0; wait_clk(H);
    run_word(16'h01AA, 10, 1'b1, mi);
    wait_clk(H); ss_n = 1'b1; wait_clk(6);
    chk(rx_ready == 1'b1, "R8 coincident ready", {15'h0, rx_ready}, 16'h1);
    chk(rx_overrun == 1'b0, "R8 coincident no overrun", {15'h0, rx_overrun}, 16'h0);
    chk(rx_data == 16'h01AA, "R8 coincident data", rx_data, 16'h01AA);
    read_data();
    chk(rx_ready == 1'b0, "R8 final clear", {15'h0, rx_ready}, 16'h0);

    // R5: back-to-back words in one selection, tx written mid-word
    write_tx(16'h0321);
    ss_n = 1'b0; wait_clk(H);
    write_tx(16'h02DE);
    run_word(16'h0111, 10, 1'b0, mi);
    run_word(16'h0222, 10, 1'b0, mi2);
    wait_clk(H); ss_n = 1'b1; wait_clk(6);
    chk(mi == 16'h0321, "R5 first tx word", mi, 16'h0321);
    chk(mi2 == 16'h02DE, "R5 reloaded tx word", mi2, 16'h02DE);
    chk(rx_data == 16'h0222, "R9 back-to-back data", rx_data, 16'h0222);
    chk(rx_overrun == 1'b1, "R9 back-to-back overrun", {15'h0, rx_overrun}, 16'h1);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule